// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the byte-wide register side of a two-channel asynchronous serial controller. A host reaches either channel through two ports, a control port and a data port. Two address bits pick the port: bit 0 selects control (0) or data (1), and bit 1 selects channel A (1) or channel B (0). Control registers are reached indirectly. A write to control register 0 loads a register pointer, and the next control access on that channel reaches the register the pointer names. The pointer then returns to 0.

Each channel keeps sixteen write registers and a small set of read registers. It decodes commands written to register 0, and software writes to register 9 can reset either channel or both. The block tracks receive and transmit interrupt pending and in-service state for both channels. From that state it builds one shared interrupt vector, a pending-bits register and a single interrupt line. The line side is modelled by simple holding registers: a received byte arrives with a strobe, a break event arrives as a pulse, and a transmitted byte leaves as a one-cycle strobe.

Top module: `dual_serial_regif`

## Requirements
- R1: A control write with pointer 0 loads the pointer from data bits 2:0. Bit 3 of the pointer is set when bits 5:3 hold command 1. The next control write to a nonzero pointer stores the byte in that write register, and the pointer goes back to 0.
- R2: A control read returns the read register at the pointer (RR0 at pointer 0, RR1 at pointer 1) and leaves the pointer at 0.
- R3: After reset, each channel's RR0 reads 0x44, RR1 reads 0x07, the vector (channel B pointer 2) reads 0x00, and irq_o and tx_valid_o are 0.
- R4: A data write holds the byte and sets RR0 bit 2 and RR1 bit 0. In the next cycle it pulses tx_valid_o for that channel with the byte on tx_data_o, but only when write register 5 bit 3 is set. It also raises that channel's transmit interrupt.
- R5: A received byte is taken only when write register 3 bit 0 is set and RR0 bit 0 is clear. Taking it sets RR0 bit 0 and raises a receive interrupt. A byte offered while one is waiting is dropped.
- R6: A data read returns the held byte and clears RR0 bit 0 and the channel's receive interrupt.
- R7: The vector is read at channel B pointer 2. With write register 9 bit 4 clear, the codes are 0x0C (receive A), 0x04 (receive B), 0x08 (transmit A), 0x00 (transmit B) and 0x06 (none). With it set, the codes are 0x30, 0x20, 0x10, 0x00 and 0x60.
- R8: A new interrupt of one type loads the vector only when the other type on the same channel is not in service.
- R9: Command 5 (bits 5:3 = 101) clears the transmit interrupt. Command 7 clears receive if receive is in service, otherwise transmit. Clearing one type re-raises the other type if it is still pending, and this reloads the vector.
- R10: Bits 7:6 of a write to register 9 reset channel B (01), channel A (10) or both (11), and the byte is not stored. A reset of channel B zeroes the vector.
- R11: Channel A pointer 3 reads the pending bits: bit 1 transmit B, bit 2 receive B, bit 4 transmit A, bit 5 receive A. The other bits are 0.
- R12: irq_o is the OR over both channels of three terms: write register 1 bit 1 with transmit pending; write register 1 bits 4:3 equal to 01 or 10 with receive pending; write register 15 bit 7 with RR0 bit 7 (the sticky break flag set by brk_i).
- R13: Writes to registers 12 and 13 are also readable at pointers 12 and 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (ignored when wr_i is set) |
| addr_i | input | 2 | Bit 0: control/data; bit 1: channel A/B |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, valid while rd_i is high |
| rx_valid_i | input | 2 | Received-byte strobe per channel (bit 1 = A) |
| rx_data_i | input | 16 | Received bytes, channel A in bits 15:8 |
| brk_i | input | 2 | Break event per channel |
| tx_valid_o | output | 2 | Transmit strobe per channel |
| tx_data_o | output | 16 | Transmitted bytes, channel A in bits 15:8 |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest state to reach from the ports is a channel with both interrupt types pending while the later one is held off the vector because the earlier one is in service. Clearing the in-service type should then bring the held one back onto the vector. The stimulus gets there by writing a transmit byte and then offering a received byte on the same channel. It then issues command 5 and command 7 in turn, and reads the vector and pending bits after each step. High-mode codes, the fixed transmit-B code and the software resets of each channel are reached the same way, from the pointer writes.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int DW     = 8;
  localparam int NREG   = 16;
  localparam int PTR_W  = $clog2(NREG);
  localparam int NCH    = 2;
  localparam int CH_B   = 0;
  localparam int CH_A   = 1;

  localparam logic [DW-1:0] RR0_RST = 8'h44;
  localparam logic [DW-1:0] RR1_RST = 8'h07;

  typedef struct packed {
    logic [NCH-1:0] rxint;
    logic [NCH-1:0] txint;
    logic [NCH-1:0] rxsvc;
    logic [NCH-1:0] txsvc;
    logic [DW-1:0]  vec;
  } irq_st_t;

  function automatic logic [DW-1:0] wreg_rst(input int idx);
    case (idx)
      4:       return 8'h04;
      9:       return 8'hC0;
      11:      return 8'h08;
      14:      return 8'h30;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] code_none(input logic hi);
    return hi ? 8'h60 : 8'h06;
  endfunction

  function automatic logic [DW-1:0] code_rx(input int c, input logic hi);
    if (c == CH_A) return hi ? 8'h30 : 8'h0C;
    return hi ? 8'h20 : 8'h04;
  endfunction

  function automatic logic [DW-1:0] code_tx(input int c, input logic hi);
    if (c == CH_A) return hi ? 8'h10 : 8'h08;
    return 8'h00;
  endfunction

  function automatic irq_st_t f_set_rx(input irq_st_t s, input int c, input logic hi);
    irq_st_t r = s;
    r.rxint[c] = 1'b1;
    if (!r.txsvc[c]) begin
      r.rxsvc[c] = 1'b1;
      r.vec      = code_rx(c, hi);
    end
    return r;
  endfunction

  function automatic irq_st_t f_set_tx(input irq_st_t s, input int c, input logic hi);
    irq_st_t r = s;
    r.txint[c] = 1'b1;
    if (!r.rxsvc[c]) begin
      r.txsvc[c] = 1'b1;
      r.vec      = code_tx(c, hi);
    end
    return r;
  endfunction

  function automatic irq_st_t f_clr_rx(input irq_st_t s, input int c, input logic hi);
    irq_st_t r = s;
    r.rxint[c] = 1'b0;
    r.rxsvc[c] = 1'b0;
    r.vec      = code_none(hi);
    if (r.txint[c]) r = f_set_tx(r, c, hi);
    return r;
  endfunction

  function automatic irq_st_t f_clr_tx(input irq_st_t s, input int c, input logic hi);
    irq_st_t r = s;
    r.txint[c] = 1'b0;
    r.txsvc[c] = 1'b0;
    r.vec      = code_none(hi);
    if (r.rxint[c]) r = f_set_rx(r, c, hi);
    return r;
  endfunction
endpackage

// File: rtl/dsr_chan.sv
module dsr_chan
  import dsr_pkg::*;
#(
  parameter int W  = DW,
  parameter int NR = NREG,
  localparam int PW = $clog2(NR)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_rst_i,
  input  logic         wr_ctrl_i,
  input  logic         wr_data_i,
  input  logic         rd_ctrl_i,
  input  logic         rd_data_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rx_valid_i,
  input  logic [W-1:0] rx_data_i,
  input  logic         brk_i,
  output logic [PW-1:0] ptr_o,
  output logic [W-1:0] rr_o,
  output logic [W-1:0] rx_hold_o,
  output logic         tx_valid_o,
  output logic [W-1:0] tx_data_o,
  output logic         set_rx_o,
  output logic         set_tx_o,
  output logic         clr_rx_o,
  output logic         clr_tx_o,
  output logic         clr_ius_o,
  output logic [1:0]   rst_req_o,
  output logic         status_hi_o,
  output logic         tx_ie_o,
  output logic         rx_ie_o,
  output logic         brk_en_o,
  output logic         brk_o
);
  localparam logic [PW-1:0] P_RST = PW'(9);
  localparam logic [PW-1:0] P_BLO = PW'(12);
  localparam logic [PW-1:0] P_BHI = PW'(13);

  logic [W-1:0]  wreg [NR];
  logic [PW-1:0] ptr;
  logic [W-1:0]  rr0, rr1, rr12, rr13, rx_hold, tx_hold;
  logic          tx_valid_q;
  logic [2:0]    cmd;
  logic          is_cmd, rx_acc;

  assign cmd    = wdata_i[5:3];
  assign is_cmd = wr_ctrl_i && (ptr == '0);
  assign rx_acc = rx_valid_i && wreg[3][0] && !rr0[0];

  assign set_rx_o  = rx_acc && !sw_rst_i;
  assign set_tx_o  = wr_data_i && !sw_rst_i;
  assign clr_rx_o  = rd_data_i && !sw_rst_i;
  assign clr_tx_o  = is_cmd && (cmd == 3'd5) && !sw_rst_i;
  assign clr_ius_o = is_cmd && (cmd == 3'd7) && !sw_rst_i;
  assign rst_req_o = (wr_ctrl_i && ptr == P_RST) ? wdata_i[7:6] : 2'b00;

  assign status_hi_o = wreg[9][4];
  assign tx_ie_o     = wreg[1][1];
  assign rx_ie_o     = (wreg[1][4:3] == 2'b01) || (wreg[1][4:3] == 2'b10);
  assign brk_en_o    = wreg[15][7];
  assign brk_o       = rr0[7];

  assign ptr_o      = ptr;
  assign rx_hold_o  = rx_hold;
  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_hold;

  always_comb begin
    case (ptr)
      PW'(0):  rr_o = rr0;
      PW'(1):  rr_o = rr1;
      P_BLO:   rr_o = rr12;
      P_BHI:   rr_o = rr13;
      default: rr_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NR; i++) wreg[i] <= wreg_rst(i);
      ptr <= '0; rr0 <= RR0_RST; rr1 <= RR1_RST; rr12 <= '0; rr13 <= '0;
      rx_hold <= '0; tx_hold <= '0; tx_valid_q <= 1'b0;
    end else if (sw_rst_i) begin
      for (int i = 0; i < NR; i++) wreg[i] <= wreg_rst(i);
      ptr <= '0; rr0 <= RR0_RST; rr1 <= RR1_RST; rr12 <= '0; rr13 <= '0;
      rx_hold <= '0; tx_hold <= '0; tx_valid_q <= 1'b0;
    end else begin
      tx_valid_q <= wr_data_i && wreg[5][3];
      if (wr_ctrl_i) begin
        if (ptr == '0) begin
          ptr <= {(cmd == 3'd1), wdata_i[2:0]};
        end else begin
          ptr <= '0;
          if (ptr != P_RST || wdata_i[7:6] == 2'b00) wreg[ptr] <= wdata_i;
          if (ptr == P_BLO) rr12 <= wdata_i;
          if (ptr == P_BHI) rr13 <= wdata_i;
        end
      end else if (rd_ctrl_i) begin
        ptr <= '0;
      end
      if (wr_data_i) begin
        tx_hold <= wdata_i;
        rr0[2]  <= 1'b1;
        rr1[0]  <= 1'b1;
      end
      if (rd_data_i) rr0[0] <= 1'b0;
      if (rx_acc) begin
        rr0[0]  <= 1'b1;
        rx_hold <= rx_data_i;
      end
      if (brk_i) rr0[7] <= 1'b1;
    end
  end

  // R2: any control read leaves the pointer at register 0
  a_r2_ptr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ctrl_i && !wr_ctrl_i) |=> (ptr == '0));
  // R1: an access to a nonzero register falls back to register 0
  a_r1_ptr_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl_i && ptr != '0) |=> (ptr == '0));
  // R5: a waiting byte is not overwritten
  a_r5_hold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr0[0] && !rd_data_i && !sw_rst_i) |=> ($stable(rx_hold) && rr0[0]));
  // R4: a data write leaves both empty flags set
  a_r4_tx_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data_i && !sw_rst_i) |=> (rr0[2] && rr1[0]));
endmodule

// File: rtl/dsr_intr.sv
module dsr_intr
  import dsr_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] sw_rst_i,
  input  logic [NCH-1:0] set_rx_i,
  input  logic [NCH-1:0] set_tx_i,
  input  logic [NCH-1:0] clr_rx_i,
  input  logic [NCH-1:0] clr_tx_i,
  input  logic [NCH-1:0] clr_ius_i,
  input  logic [NCH-1:0] hi_i,
  output logic [NCH-1:0] rxint_o,
  output logic [NCH-1:0] txint_o,
  output logic [DW-1:0]  vec_o
);
  irq_st_t st, st_d;

  // events of one cycle applied in order: reset, clears, transmit, receive
  always_comb begin
    st_d = st;
    for (int c = 0; c < NCH; c++) begin
      if (sw_rst_i[c]) begin
        st_d.rxint[c] = 1'b0;
        st_d.txint[c] = 1'b0;
        st_d.rxsvc[c] = 1'b0;
        st_d.txsvc[c] = 1'b0;
        if (c == CH_B) st_d.vec = '0;
      end else begin
        if (clr_rx_i[c]) st_d = f_clr_rx(st_d, c, hi_i[c]);
        if (clr_tx_i[c]) st_d = f_clr_tx(st_d, c, hi_i[c]);
        if (clr_ius_i[c]) begin
          if (st_d.rxsvc[c])      st_d = f_clr_rx(st_d, c, hi_i[c]);
          else if (st_d.txsvc[c]) st_d = f_clr_tx(st_d, c, hi_i[c]);
        end
        if (set_tx_i[c]) st_d = f_set_tx(st_d, c, hi_i[c]);
        if (set_rx_i[c]) st_d = f_set_rx(st_d, c, hi_i[c]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st <= '0;
    else         st <= st_d;
  end

  assign rxint_o = st.rxint;
  assign txint_o = st.txint;
  assign vec_o   = st.vec;

  // R8: on one channel at most one type is in service
  a_r8_svc_excl_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({st.rxsvc[CH_B], st.txsvc[CH_B]}));
  a_r8_svc_excl_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({st.rxsvc[CH_A], st.txsvc[CH_A]}));
  // R9: in service implies pending
  a_r9_svc_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st.rxsvc & ~st.rxint) == '0) && ((st.txsvc & ~st.txint) == '0));
endmodule

// File: rtl/dual_serial_regif.sv
module dual_serial_regif
  import dsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NCH-1:0]    rx_valid_i,
  input  logic [NCH*DW-1:0] rx_data_i,
  input  logic [NCH-1:0]    brk_i,
  output logic [NCH-1:0]    tx_valid_o,
  output logic [NCH*DW-1:0] tx_data_o,
  output logic              irq_o
);
  logic [NCH-1:0] set_rx, set_tx, clr_rx, clr_tx, clr_ius, hi;
  logic [NCH-1:0] tx_ie, rx_ie, brk_en, brk, rxint, txint, sw_rst;
  logic [1:0]       rst_req [NCH];
  logic [PTR_W-1:0] ptr     [NCH];
  logic [DW-1:0]    rr      [NCH];
  logic [DW-1:0]    rx_hold [NCH];
  logic [DW-1:0]    vec, pend;
  logic             rd_eff;

  assign rd_eff = rd_i && !wr_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam bit SEL = (g == CH_A);
    dsr_chan u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sw_rst_i    (sw_rst[g]),
      .wr_ctrl_i   (wr_i   && addr_i[1] == SEL && !addr_i[0]),
      .wr_data_i   (wr_i   && addr_i[1] == SEL &&  addr_i[0]),
      .rd_ctrl_i   (rd_eff && addr_i[1] == SEL && !addr_i[0]),
      .rd_data_i   (rd_eff && addr_i[1] == SEL &&  addr_i[0]),
      .wdata_i     (wdata_i),
      .rx_valid_i  (rx_valid_i[g]),
      .rx_data_i   (rx_data_i[g*DW +: DW]),
      .brk_i       (brk_i[g]),
      .ptr_o       (ptr[g]),
      .rr_o        (rr[g]),
      .rx_hold_o   (rx_hold[g]),
      .tx_valid_o  (tx_valid_o[g]),
      .tx_data_o   (tx_data_o[g*DW +: DW]),
      .set_rx_o    (set_rx[g]),
      .set_tx_o    (set_tx[g]),
      .clr_rx_o    (clr_rx[g]),
      .clr_tx_o    (clr_tx[g]),
      .clr_ius_o   (clr_ius[g]),
      .rst_req_o   (rst_req[g]),
      .status_hi_o (hi[g]),
      .tx_ie_o     (tx_ie[g]),
      .rx_ie_o     (rx_ie[g]),
      .brk_en_o    (brk_en[g]),
      .brk_o       (brk[g])
    );
  end

  // reset code 01 hits channel B, 10 channel A, from either channel
  assign sw_rst[CH_B] = rst_req[CH_B][0] | rst_req[CH_A][0];
  assign sw_rst[CH_A] = rst_req[CH_B][1] | rst_req[CH_A][1];

  dsr_intr u_intr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_rst_i  (sw_rst),
    .set_rx_i  (set_rx),
    .set_tx_i  (set_tx),
    .clr_rx_i  (clr_rx),
    .clr_tx_i  (clr_tx),
    .clr_ius_i (clr_ius),
    .hi_i      (hi),
    .rxint_o   (rxint),
    .txint_o   (txint),
    .vec_o     (vec)
  );

  assign pend = {2'b00, rxint[CH_A], txint[CH_A], 1'b0,
                 rxint[CH_B], txint[CH_B], 1'b0};

  always_comb begin
    if (addr_i[0])
      rdata_o = rx_hold[addr_i[1]];
    else if (!addr_i[1] && ptr[CH_B] == PTR_W'(2))
      rdata_o = vec;
    else if (addr_i[1] && ptr[CH_A] == PTR_W'(3))
      rdata_o = pend;
    else
      rdata_o = rr[addr_i[1]];
  end

  assign irq_o = |((tx_ie & txint) | (rx_ie & rxint) | (brk_en & brk));

  // R12: with nothing pending and no break seen the line stays low
  a_r12_irq_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxint == '0 && txint == '0 && brk == '0) |-> !irq_o);
endmodule

// File: tb/dual_serial_regif_tb.sv
module dual_serial_regif_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [1:0]  rx_valid_i = '0;
  logic [15:0] rx_data_i = '0;
  logic [1:0]  brk_i = '0;
  logic [1:0]  tx_valid_o;
  logic [15:0] tx_data_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dual_serial_regif u_dut (.*);

  localparam logic [1:0] AC = 2'b10, AD = 2'b11, BC = 2'b00, BD = 2'b01;
  localparam logic [1:0] OW = 2'd0, OR = 2'd1, OX = 2'd2;

  // {req, op, addr, data, expected}
  localparam int NV = 61;
  localparam logic [23:0] VEC [NV] = '{
    {4'd3, OR, BC, 8'h00, 8'h44},  // R3 RR0 after reset
    {4'd3, OW, BC, 8'h02, 8'h00},
    {4'd3, OR, BC, 8'h00, 8'h00},  // R3 vector after reset
    {4'd1, OW, AC, 8'h01, 8'h00},
    {4'd2, OR, AC, 8'h00, 8'h07},  // R2 RR1
    {4'd2, OR, AC, 8'h00, 8'h44},  // R2 back to RR0
    {4'd1, OW, AC, 8'h0C, 8'h00},  // R1 cmd 1 + 4 -> 12
    {4'd1, OW, AC, 8'h5A, 8'h00},
    {4'd1, OW, AC, 8'h0C, 8'h00},
    {4'd13,OR, AC, 8'h00, 8'h5A},  // R13
    {4'd5, OW, AC, 8'h03, 8'h00},
    {4'd5, OW, AC, 8'h01, 8'h00},
    {4'd5, OX, AC, 8'h3C, 8'h00},
    {4'd5, OR, AC, 8'h00, 8'h45},  // R5 char available
    {4'd7, OW, BC, 8'h02, 8'h00},
    {4'd7, OR, BC, 8'h00, 8'h0C},  // R7 rx A low
    {4'd11,OW, AC, 8'h03, 8'h00},
    {4'd11,OR, AC, 8'h00, 8'h20},  // R11 rx A pending
    {4'd5, OX, AC, 8'h77, 8'h00},  // R5 dropped
    {4'd6, OR, AD, 8'h00, 8'h3C},  // R6
    {4'd6, OR, AC, 8'h00, 8'h44},  // R6 flag cleared
    {4'd7, OW, BC, 8'h02, 8'h00},
    {4'd7, OR, BC, 8'h00, 8'h06},  // R7 none low
    {4'd4, OW, AD, 8'h41, 8'h00},
    {4'd7, OW, BC, 8'h02, 8'h00},
    {4'd7, OR, BC, 8'h00, 8'h08},  // R7 tx A low
    {4'd11,OW, AC, 8'h03, 8'h00},
    {4'd11,OR, AC, 8'h00, 8'h10},  // R11 tx A pending
    {4'd8, OX, AC, 8'h11, 8'h00},
    {4'd8, OW, BC, 8'h02, 8'h00},
    {4'd8, OR, BC, 8'h00, 8'h08},  // R8 tx in service keeps vector
    {4'd9, OW, AC, 8'h28, 8'h00},
    {4'd9, OW, BC, 8'h02, 8'h00},
    {4'd9, OR, BC, 8'h00, 8'h0C},  // R9 rx re-raised
    {4'd9, OW, AD, 8'h42, 8'h00},
    {4'd9, OW, AC, 8'h38, 8'h00},
    {4'd9, OW, BC, 8'h02, 8'h00},
    {4'd9, OR, BC, 8'h00, 8'h08},  // R9 cmd 7 clears rx first
    {4'd11,OW, AC, 8'h03, 8'h00},
    {4'd11,OR, AC, 8'h00, 8'h10},
    {4'd6, OR, AD, 8'h00, 8'h11},
    {4'd9, OW, AC, 8'h38, 8'h00},
    {4'd9, OW, BC, 8'h02, 8'h00},
    {4'd9, OR, BC, 8'h00, 8'h06},  // R9 cmd 7 then clears tx
    {4'd7, OW, AC, 8'h09, 8'h00},
    {4'd7, OW, AC, 8'h10, 8'h00},
    {4'd7, OW, AD, 8'h43, 8'h00},
    {4'd7, OW, BC, 8'h02, 8'h00},
    {4'd7, OR, BC, 8'h00, 8'h10},  // R7 tx A high
    {4'd7, OW, AC, 8'h28, 8'h00},
    {4'd7, OW, BC, 8'h02, 8'h00},
    {4'd7, OR, BC, 8'h00, 8'h60},  // R7 none high
    {4'd7, OW, BC, 8'h03, 8'h00},
    {4'd7, OW, BC, 8'h01, 8'h00},
    {4'd7, OW, BC, 8'h09, 8'h00},
    {4'd7, OW, BC, 8'h10, 8'h00},
    {4'd7, OW, BD, 8'h44, 8'h00},
    {4'd8, OX, BC, 8'h99, 8'h00},
    {4'd9, OW, BC, 8'h28, 8'h00},
    {4'd9, OW, BC, 8'h02, 8'h00},
    {4'd9, OR, BC, 8'h00, 8'h20}   // R9 rx B high reloaded
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    #5 chk(req, rdata_o, exp);
    @(posedge clk_i); #1;
    rd_i = 1'b0;
  endtask

  task automatic rx(input int c, input logic [7:0] d);
    @(negedge clk_i);
    rx_valid_i[c] = 1'b1; rx_data_i[c*8 +: 8] = d;
    @(posedge clk_i); #1;
    rx_valid_i = '0;
  endtask

  task automatic brk(input int c);
    @(negedge clk_i);
    brk_i[c] = 1'b1;
    @(posedge clk_i); #1;
    brk_i = '0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    #2;
    chk("R3 irq", {7'b0, irq_o}, 8'h00);
    chk("R3 tx_valid", {6'b0, tx_valid_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq; logic [1:0] op, ad; logic [7:0] dt, ex;
      {rq, op, ad, dt, ex} = VEC[i];
      case (op)
        OW: wr(ad, dt);
        OR: rd(ad, ex, $sformatf("R%0d vec %0d", rq, i));
        default: rx(ad[1] ? 1 : 0, dt);
      endcase
    end

    // R11 rx B pending; R6 read B
    wr(AC, 8'h03); rd(AC, 8'h04, "R11 rx B pending");
    rd(BD, 8'h99, "R6 read B");
    wr(BC, 8'h02); rd(BC, 8'h60, "R6 vector after read B");

    // R10 reset B issued from channel A
    wr(BC, 8'h0C); wr(BC, 8'h33);
    wr(AC, 8'h09); wr(AC, 8'h40);
    wr(BC, 8'h0C); rd(BC, 8'h00, "R10 B cleared");
    wr(AC, 8'h0C); rd(AC, 8'h5A, "R10 A untouched");
    wr(BC, 8'h02); rd(BC, 8'h00, "R10 vector zeroed");
    // R10 reset A clears its high-mode bit
    wr(AC, 8'h09); wr(AC, 8'h80);
    wr(AC, 8'h0C); rd(AC, 8'h00, "R10 A cleared");
    wr(AD, 8'h45);
    wr(BC, 8'h02); rd(BC, 8'h08, "R10 A low mode");
    // R10 both, high bit in the same byte not stored
    wr(BC, 8'h09); wr(BC, 8'hD0);
    wr(AD, 8'h46);
    wr(BC, 8'h02); rd(BC, 8'h08, "R10 not stored");
    rd(AC, 8'h44, "R10 A RR0");

    // R4 transmit strobe
    wr(AC, 8'h05); wr(AC, 8'h08);
    wr(AD, 8'h55);
    chk("R4 tx_valid", {6'b0, tx_valid_o}, 8'h02);
    chk("R4 tx_data", tx_data_o[15:8], 8'h55);
    @(posedge clk_i); #1;
    chk("R4 tx pulse ends", {6'b0, tx_valid_o}, 8'h00);
    wr(BD, 8'h66);
    chk("R4 disabled no tx", {6'b0, tx_valid_o}, 8'h00);

    // R12 interrupt line
    chk("R12 masked", {7'b0, irq_o}, 8'h00);
    wr(AC, 8'h01); wr(AC, 8'h02);
    chk("R12 tx enabled", {7'b0, irq_o}, 8'h01);
    wr(AC, 8'h28);
    chk("R12 tx cleared", {7'b0, irq_o}, 8'h00);
    brk(0);
    chk("R12 break", {7'b0, irq_o}, 8'h01);
    rd(BC, 8'hC4, "R12 break flag");
    wr(BC, 8'h0F); wr(BC, 8'h00);
    chk("R12 break masked", {7'b0, irq_o}, 8'h00);
    wr(AC, 8'h03); wr(AC, 8'h01);
    wr(AC, 8'h01); wr(AC, 8'h08);
    rx(1, 8'h21);
    chk("R12 rx mode 01", {7'b0, irq_o}, 8'h01);
    wr(AC, 8'h01); wr(AC, 8'h18);
    chk("R12 rx mode 11", {7'b0, irq_o}, 8'h00);
    wr(AC, 8'h01); wr(AC, 8'h10);
    chk("R12 rx mode 10", {7'b0, irq_o}, 8'h01);

    summary();
  end
endmodule